// File: doc/BRIEF.md
# ATM OAM Cell Classifier and Extractor

This block sits in the receive path of an ATM cell stream carried one byte per clock. A start-of-cell marker accompanies the first byte of every 53-byte cell. The block reads the four header octets and sorts the cell into one of three groups: an ordinary user cell, a segment OAM cell, or an end-to-end OAM cell. OAM cells are recognised at both the virtual-path level (F4, identified by a reserved VCI) and the virtual-channel level (F5, identified by the payload-type bits).

Segment OAM cells end at this link, so they are removed from the forward stream. The exception is a cell for which an external user cell filter reports a pass hit. Every other cell is forwarded without change once its last byte has arrived. Forwarding uses a two-bank cell store, so the input never stalls.

When the OAM capture enable is set, every OAM cell of either kind is copied whole into a one-cell buffer that a host reads by byte address. A sticky interrupt then tells the host that a cell is waiting.

Top module: `oam_cell_proc`

## Requirements
- R1: A cell is an F4 OAM cell when all of the following hold: the upper nibble of header octet 1 is 0; the 16-bit VCI is 3 (segment) or 4 (end-to-end); bits 3 and 1 of octet 4 are 0. The VCI is octet 2 bits 3:0, then octet 3, then octet 4 bits 7:4. VPI bits and octet 4 bits 2 and 0 are ignored.
- R2: A cell is an F5 OAM cell when the upper nibble of octet 1 is 0, the VCI is nonzero, and octet 4 bits 3:1 are 100 (segment) or 101 (end-to-end). Any other header is a user cell.
- R3: A segment OAM cell with `filt_pass` low is dropped, and none of its bytes appear at the output.
- R4: A segment OAM cell with `filt_pass` high is forwarded. `filt_pass` is sampled together with header octet 4.
- R5: A forwarded cell leaves as 53 consecutive valid bytes, identical to the input. `out_sop` marks the first byte, which appears in the cycle after the cell's last input byte.
- R6: When `oam_chk_en` is high with the last byte of an OAM cell, all 53 bytes become readable at `hrd_addr` 0..52, and `irq` is high from the next cycle on.
- R7: When `oam_chk_en` is low with the last byte, the capture buffer keeps its contents and `irq` is not set by that cell.
- R8: `irq` stays high until a cycle with `irq_clr` high that has no new capture. A new capture while `irq` is high overwrites the buffer.
- R9: After reset, `out_valid` and `irq` are low and every capture byte reads 0.
- R10: A host read at an address of 53 or above returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input byte valid |
| in_sop | input | 1 | First byte of a cell |
| in_data | input | 8 | Input cell byte |
| filt_pass | input | 1 | User cell filter pass hit, sampled with header octet 4 |
| oam_chk_en | input | 1 | OAM capture enable, sampled with the last byte |
| out_valid | output | 1 | Forward byte valid |
| out_sop | output | 1 | First byte of a forwarded cell |
| out_data | output | 8 | Forward cell byte |
| hrd_addr | input | 6 | Host read byte address into the capture buffer |
| hrd_data | output | 8 | Capture buffer byte at hrd_addr |
| irq_clr | input | 1 | Clears the OAM interrupt |
| irq | output | 1 | Sticky OAM cell received interrupt |

## Verification
A wrong class decision shows up in the first cycle after the cell's last byte. A cell that should be dropped puts out a start marker there, or a cell that should be forwarded does not, and `irq` disagrees with the expected capture. A wrong bank select or byte index in the cell store shows up as a payload mismatch somewhere within the next 53 output bytes. A fault in the capture copy shows up in the host reads made in the gap that follows each cell. The bench sweeps 256 headers across every VCI class, every low nibble of octet 4, and zero and nonzero GFC, with the filter, enable and clear inputs rotated on separate periods.

// File: rtl/oam_pkg.sv
package oam_pkg;

   typedef enum logic [2:0] {
      CLS_USER,
      CLS_F4_SEG,
      CLS_F4_E2E,
      CLS_F5_SEG,
      CLS_F5_E2E
   } oam_cls_e;

   // hdr[31:24] is header octet 1, hdr[7:0] is octet 4
   function automatic oam_cls_e oam_classify(input logic [31:0] hdr);
      logic [15:0] vci;
      logic        gfc_zero;
      logic [2:0]  pti;
      vci      = hdr[19:4];
      gfc_zero = (hdr[31:28] == 4'd0);
      pti      = hdr[3:1];
      if (gfc_zero && !hdr[3] && !hdr[1] && vci == 16'd3)       return CLS_F4_SEG;
      else if (gfc_zero && !hdr[3] && !hdr[1] && vci == 16'd4)  return CLS_F4_E2E;
      else if (gfc_zero && vci != 16'd0 && pti == 3'b100)       return CLS_F5_SEG;
      else if (gfc_zero && vci != 16'd0 && pti == 3'b101)       return CLS_F5_E2E;
      else                                                      return CLS_USER;
   endfunction

   function automatic logic cls_is_oam(input oam_cls_e c);
      return c != CLS_USER;
   endfunction

   function automatic logic cls_is_seg(input oam_cls_e c);
      return (c == CLS_F4_SEG) || (c == CLS_F5_SEG);
   endfunction

endpackage

// File: rtl/oam_hdr_class.sv
module oam_hdr_class import oam_pkg::*; #(
   parameter  int CELL_BYTES = 53,
   parameter  int DW         = 8,
   localparam int IW         = $clog2(CELL_BYTES)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic          in_sop,
   input  logic [DW-1:0] in_data,
   input  logic          filt_pass,
   output logic [IW-1:0] cur_idx,
   output logic          cell_done,
   output oam_cls_e      cls,
   output logic          filt_q
);
   localparam int HDR_BYTES = 4;
   localparam logic [IW-1:0] LAST_IDX = IW'(CELL_BYTES - 1);
   localparam logic [IW-1:0] CLS_IDX  = IW'(HDR_BYTES - 1);

   if (DW != 8) begin : g_dw_bad
      $error("oam_hdr_class: header octets must be 8 bits wide");
   end
   if (CELL_BYTES <= HDR_BYTES) begin : g_len_bad
      $error("oam_hdr_class: cell shorter than its header");
   end

   logic [IW-1:0] pos_q;
   logic [DW-1:0] hdr_q [HDR_BYTES-1];

   assign cur_idx   = in_sop ? '0 : pos_q;
   assign cell_done = in_valid && (cur_idx == LAST_IDX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        pos_q <= '0;
      else if (in_valid) pos_q <= (cur_idx == LAST_IDX) ? '0 : cur_idx + 1'b1;
   end

   for (genvar k = 0; k < HDR_BYTES - 1; k++) begin : g_hdr
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                   hdr_q[k] <= '0;
         else if (in_valid && cur_idx == IW'(k))       hdr_q[k] <= in_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cls    <= CLS_USER;
         filt_q <= 1'b0;
      end else if (in_valid && cur_idx == CLS_IDX) begin
         cls    <= oam_classify({hdr_q[0], hdr_q[1], hdr_q[2], in_data});
         filt_q <= filt_pass;
      end
   end

   // R5
   sop_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_sop) |=> (pos_q == IW'(1)));

endmodule

// File: rtl/oam_cell_store.sv
module oam_cell_store #(
   parameter  int CELL_BYTES = 53,
   parameter  int DW         = 8,
   localparam int IW         = $clog2(CELL_BYTES)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [IW-1:0] wr_idx,
   input  logic [DW-1:0] wr_data,
   input  logic          cell_done,
   input  logic          fwd,
   output logic [DW-1:0] cell_img [CELL_BYTES],
   output logic          out_valid,
   output logic          out_sop,
   output logic [DW-1:0] out_data
);
   localparam logic [IW-1:0] LAST_IDX = IW'(CELL_BYTES - 1);

   logic [DW-1:0] mem_q [2][CELL_BYTES];
   logic          wbank_q, sbank_q, send_q;
   logic [IW-1:0] sidx_q;

   always_ff @(posedge clk) begin
      if (wr_en) mem_q[wbank_q][wr_idx] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wbank_q <= 1'b0;
         sbank_q <= 1'b0;
         send_q  <= 1'b0;
         sidx_q  <= '0;
      end else begin
         if (cell_done) wbank_q <= ~wbank_q;
         if (cell_done && fwd) begin
            send_q  <= 1'b1;
            sbank_q <= wbank_q;
            sidx_q  <= '0;
         end else if (send_q) begin
            if (sidx_q == LAST_IDX) send_q <= 1'b0;
            else                    sidx_q <= sidx_q + 1'b1;
         end
      end
   end

   always_comb begin
      for (int i = 0; i < CELL_BYTES; i++) begin
         cell_img[i] = (wr_en && wr_idx == IW'(i)) ? wr_data : mem_q[wbank_q][i];
      end
   end

   assign out_valid = send_q;
   assign out_sop   = send_q && (sidx_q == '0);
   assign out_data  = send_q ? mem_q[sbank_q][sidx_q] : '0;

   // R5
   fwd_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cell_done && fwd) |=> (out_valid && out_sop));
   // R3
   drop_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cell_done && !fwd) |=> !out_sop);
   // R5
   sop_in_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_sop |-> out_valid);

endmodule

// File: rtl/oam_capture.sv
module oam_capture #(
   parameter  int CELL_BYTES = 53,
   parameter  int DW         = 8,
   parameter  bit RD_REG     = 1'b0,
   localparam int IW         = $clog2(CELL_BYTES)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cap_en,
   input  logic [DW-1:0] cell_img [CELL_BYTES],
   input  logic [IW-1:0] hrd_addr,
   input  logic          irq_clr,
   output logic [DW-1:0] hrd_data,
   output logic          irq
);
   logic [DW-1:0] cap_q [CELL_BYTES];
   logic [DW-1:0] rd_val;
   logic          irq_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < CELL_BYTES; i++) cap_q[i] <= '0;
      end else if (cap_en) begin
         for (int i = 0; i < CELL_BYTES; i++) cap_q[i] <= cell_img[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       irq_q <= 1'b0;
      else if (cap_en)  irq_q <= 1'b1;
      else if (irq_clr) irq_q <= 1'b0;
   end
   assign irq = irq_q;

   assign rd_val = (int'(hrd_addr) < CELL_BYTES) ? cap_q[hrd_addr] : '0;

   if (RD_REG) begin : g_rd_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) hrd_data <= '0;
         else        hrd_data <= rd_val;
      end
   end else begin : g_rd_comb
      assign hrd_data = rd_val;
   end

   // R6
   irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(cap_en));
   // R8
   irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !irq_clr) |=> irq);
   // R8
   irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_clr && !cap_en) |=> !irq);

endmodule

// File: rtl/oam_cell_proc.sv
module oam_cell_proc import oam_pkg::*; #(
   parameter  int CELL_BYTES = 53,
   parameter  int DW         = 8,
   parameter  bit RD_REG     = 1'b0,
   localparam int IW         = $clog2(CELL_BYTES)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic          in_sop,
   input  logic [DW-1:0] in_data,
   input  logic          filt_pass,
   input  logic          oam_chk_en,
   output logic          out_valid,
   output logic          out_sop,
   output logic [DW-1:0] out_data,
   input  logic [IW-1:0] hrd_addr,
   output logic [DW-1:0] hrd_data,
   input  logic          irq_clr,
   output logic          irq
);
   logic [IW-1:0] cur_idx;
   logic          cell_done, filt_q, fwd, cap_en;
   oam_cls_e      cls;
   logic [DW-1:0] cell_img [CELL_BYTES];

   oam_hdr_class #(.CELL_BYTES(CELL_BYTES), .DW(DW)) hdr_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
      .in_data(in_data), .filt_pass(filt_pass), .cur_idx(cur_idx),
      .cell_done(cell_done), .cls(cls), .filt_q(filt_q));

   assign fwd    = !cls_is_seg(cls) || filt_q;
   assign cap_en = cell_done && cls_is_oam(cls) && oam_chk_en;

   oam_cell_store #(.CELL_BYTES(CELL_BYTES), .DW(DW)) store_i (
      .clk(clk), .rst_n(rst_n), .wr_en(in_valid), .wr_idx(cur_idx),
      .wr_data(in_data), .cell_done(cell_done), .fwd(fwd),
      .cell_img(cell_img), .out_valid(out_valid), .out_sop(out_sop),
      .out_data(out_data));

   oam_capture #(.CELL_BYTES(CELL_BYTES), .DW(DW), .RD_REG(RD_REG)) cap_i (
      .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .cell_img(cell_img),
      .hrd_addr(hrd_addr), .irq_clr(irq_clr), .hrd_data(hrd_data), .irq(irq));

   // R7
   irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(oam_chk_en && in_valid));

endmodule

// File: tb/oam_cell_proc_tb_top.sv
`timescale 1ns/1ps
module oam_cell_proc_tb_top;
   localparam int NB = 53;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic       in_valid = 1'b0, in_sop = 1'b0, filt_pass = 1'b0, oam_chk_en = 1'b0, irq_clr = 1'b0;
   logic [7:0] in_data = '0;
   logic [5:0] hrd_addr = '0;
   wire        out_valid, out_sop, irq;
   wire  [7:0] out_data, hrd_data;

   int checks = 0, errors = 0;
   logic [31:0] hdr_m [256];
   int exp_q[$];
   int cur_cell = -1, cur_j = 0, cap_cell = -1;
   bit irq_m = 1'b0;

   oam_cell_proc dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
      .in_data(in_data), .filt_pass(filt_pass), .oam_chk_en(oam_chk_en),
      .out_valid(out_valid), .out_sop(out_sop), .out_data(out_data),
      .hrd_addr(hrd_addr), .hrd_data(hrd_data), .irq_clr(irq_clr), .irq(irq));

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] vci_pick(input int k);
      case (k)
         0: return 16'h0000;
         1: return 16'h0001;
         2: return 16'h0002;
         3: return 16'h0003;
         4: return 16'h0004;
         5: return 16'h0005;
         6: return 16'h0020;
         default: return 16'hFFFF;
      endcase
   endfunction

   function automatic logic [7:0] byte_of(input int n, input int j);
      if (j < 4) return hdr_m[n][31-8*j -: 8];
      return 8'((n * 13 + j * 7) & 255);
   endfunction

   // 0 user, 1 segment OAM, 2 end-to-end OAM; 4 in bit 2 flags an F4 match
   function automatic int cls_of(input logic [31:0] h);
      logic [15:0] v;
      v = h[19:4];
      if (h[31:28] != 4'd0) return 0;
      if ((v == 16'd3 || v == 16'd4) && !h[3] && !h[1]) return (v == 16'd3) ? 5 : 6;
      if (v != 16'd0 && h[3:1] == 3'b100) return 1;
      if (v != 16'd0 && h[3:1] == 3'b101) return 2;
      return 0;
   endfunction

   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (out_sop) begin
            cur_j = 0;
            if (exp_q.size() == 0) begin
               check(1'b0, "R3 cell forwarded with none expected", 1, 0);
               cur_cell = -1;
            end else begin
               cur_cell = exp_q.pop_front();
            end
         end
         if (cur_cell >= 0 && cur_j < NB) begin
            check(out_data == byte_of(cur_cell, cur_j), "R5 forwarded byte", out_data, byte_of(cur_cell, cur_j));
         end
         cur_j++;
      end
   end

   task automatic send_cell(input int n);
      logic [31:0] h;
      int c, kind;
      bit filt, en, fwd, oam;
      string tag;
      int addrs[6];
      addrs = '{0, 1, 2, 3, 17, 52};
      h    = hdr_m[n];
      c    = cls_of(h);
      kind = c & 3;
      filt = (n % 3) == 0;
      en   = (n % 4) != 1;
      oam  = kind != 0;
      fwd  = (kind != 1) || filt;
      tag  = !oam ? "R1 R2 user" : ((c & 4) != 0 ? "R1 F4" : "R2 F5");
      for (int j = 0; j < NB; j++) begin
         @(negedge clk);
         in_valid = 1'b1; in_sop = (j == 0); in_data = byte_of(n, j);
         filt_pass = filt; oam_chk_en = en;
      end
      if (fwd) exp_q.push_back(n);
      @(negedge clk);
      in_valid = 1'b0; in_sop = 1'b0;
      if (fwd) check(out_sop && out_valid, {tag, (kind == 1) ? " R4 filter pass forwards" : " R5 forward start"}, out_sop, 1);
      else     check(!out_valid, {tag, " R3 segment dropped"}, out_valid, 0);
      if (oam && en) begin cap_cell = n; irq_m = 1'b1; end
      check(irq == irq_m, {tag, oam ? (en ? " R6 irq set" : " R7 no irq") : " R8 irq held"}, irq, irq_m);
      foreach (addrs[k]) begin
         hrd_addr = 6'(addrs[k]);
         #0.2;
         check(hrd_data == ((cap_cell < 0) ? 8'h00 : byte_of(cap_cell, addrs[k])),
               (oam && !en) ? "R7 buffer kept" : "R6 buffer content", hrd_data,
               (cap_cell < 0) ? 0 : byte_of(cap_cell, addrs[k]));
      end
      if ((n % 5) != 4) begin
         irq_clr = 1'b1;
         @(negedge clk);
         irq_clr = 1'b0; irq_m = 1'b0;
         check(irq == 1'b0, "R8 irq cleared", irq, 0);
      end else begin
         @(negedge clk);
         check(irq == irq_m, "R8 irq sticky", irq, irq_m);
      end
   endtask

   initial begin
      for (int n = 0; n < 256; n++) begin
         logic [15:0] v;
         logic [7:0]  vpi;
         logic [3:0]  gfc, lo;
         v   = vci_pick(n % 8);
         vpi = 8'((n * 5) & 255);
         gfc = n[7] ? 4'h9 : 4'h0;
         lo  = 4'((n / 8) % 16);
         hdr_m[n] = {gfc, vpi[7:4], vpi[3:0], v[15:12], v[11:4], v[3:0], lo};
      end
      repeat (3) @(negedge clk);
      check(!out_valid, "R9 out_valid after reset", out_valid, 0);
      check(!irq, "R9 irq after reset", irq, 0);
      hrd_addr = 6'd10;
      #0.2;
      check(hrd_data == 8'h00, "R9 capture after reset", hrd_data, 0);
      rst_n = 1'b1;
      @(negedge clk);
      for (int n = 0; n < 256; n++) send_cell(n);
      repeat (60) @(negedge clk);
      check(exp_q.size() == 0, "R5 all forwarded cells emitted", exp_q.size(), 0);
      hrd_addr = 6'd53;
      #0.2;
      check(hrd_data == 8'h00, "R10 read at 53", hrd_data, 0);
      hrd_addr = 6'd63;
      #0.2;
      check(hrd_data == 8'h00, "R10 read at 63", hrd_data, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #1000000;
      errors++;
      $display("FAIL R5 watchdog expired actual running expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule